// File: doc/BRIEF.md
# Converter Timing and Power-Mode Sequencer

This block times the conversions of a successive-approximation converter. A single asynchronous convert-start line controls it. It runs on the system clock and measures the power-up and conversion intervals with cycle counters. A falling edge on convert-start moves the sampler into hold and begins a conversion. When the conversion ends, the block loads the result into the serial output register and raises a one-cycle strobe.

At the end of each conversion the block reads the level of convert-start, and that level selects the power behaviour:

- **High level:** the block stays powered, and the next falling edge starts the next conversion at once.
- **Low level:** the block powers down as soon as the result is loaded.

While the block is powered down, a rising edge starts a power-up interval. A falling edge that arrives before the interval ends is remembered. The conversion then starts only when the interval has run out, so a conversion never begins unpowered.

If the serial port reports a read in progress when a conversion ends, the new result is parked and loaded only after the read finishes. A read during a conversion therefore returns the earlier result.

Top module: `adc_conv_seq`

## Requirements
- R1: After reset: `powered_o`, `converting_o` and `latch_o` are low, and `result_o` is zero.
- R2: Conversion timing when no read is in progress:
  - A conversion holds `converting_o` high for exactly CONV_CYC cycles.
  - In the cycle `converting_o` drops, `latch_o` is high for that one cycle only.
  - `result_o` then equals the `conv_data_i` value seen on the last conversion cycle.
- R3: If convert-start is high when a conversion ends, `powered_o` stays high, and the next falling edge starts a conversion with no power-up interval.
- R4: If convert-start is low when a conversion ends, `powered_o` drops in the same cycle as the latch strobe.
- R5: Convert-start passes through a two-flop synchronizer and an edge detector:
  - While powered down, a rising edge raises `powered_o` three cycles after the input changes.
  - While powered and idle, a falling edge raises `converting_o` three cycles after the input changes.
  - A high level held past the power-up interval leaves the block powered and idle.
- R6: If convert-start falls during the power-up interval, the conversion starts only when that interval ends. That is PWRUP_CYC cycles after `powered_o` rises, which is PWRUP_CYC+3 cycles after the rising input change.
- R7: If `read_busy_i` is high when a conversion ends:
  - `converting_o` stays high and `result_o` is unchanged until `read_busy_i` is seen low.
  - `latch_o` then rises in the next cycle and loads the data captured at the end of the conversion.
- R8: `result_o` changes only in a cycle with `latch_o` high, so a read during a conversion sees the previous result.
- R9: Edges on convert-start during a conversion do not change its length or produce an extra latch strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cnv_start_i | input | 1 | Asynchronous convert-start line |
| read_busy_i | input | 1 | High while the serial port is shifting a result out |
| conv_data_i | input | DATA_W | Result from the converter core, valid at the end of a conversion |
| powered_o | output | 1 | High while the converter is powered (power-up interval included) |
| converting_o | output | 1 | High from conversion start until the result is latched |
| latch_o | output | 1 | One-cycle strobe when the output register is loaded |
| result_o | output | DATA_W | Serial output register contents |

## Verification
The bench builds the block with PWRUP_CYC = 6 and CONV_CYC = 10, keeping DATA_W at 10. These short intervals let every conversion and every power-up be timed cycle by cycle within a few dozen clocks. They also leave room to toggle convert-start several times inside one conversion and to hold a read across the end of a conversion. Because the intervals are small, the exact three-cycle synchronizer latency and the stretched power-up can be checked at single-cycle resolution.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [2:0] {
    SQ_OFF   = 3'd0,
    SQ_WAKE  = 3'd1,
    SQ_READY = 3'd2,
    SQ_CONV  = 3'd3,
    SQ_PEND  = 3'd4
  } seq_state_t;
endpackage

// File: rtl/adc_seq_sync.sv
module adc_seq_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic lvl_o,
  output logic rise_o,
  output logic fall_o
);
  logic meta_q, lvl_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      lvl_q  <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      meta_q <= async_i;
      lvl_q  <= meta_q;
      prev_q <= lvl_q;
    end
  end

  assign lvl_o  = lvl_q;
  assign rise_o = lvl_q & ~prev_q;
  assign fall_o = ~lvl_q & prev_q;
endmodule

// File: rtl/adc_seq_timer.sv
module adc_seq_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             run_i,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load_i | (run_i & (cnt_q != '0));
    cnt_d  = load_i ? load_val_i : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int PWRUP_CYC = 75,
  parameter int CONV_CYC  = 115,
  parameter int CNT_W     = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_lvl_i,
  input  logic             cs_rise_i,
  input  logic             cs_fall_i,
  input  logic             busy_i,
  input  logic             tmr_done_i,
  output logic             tmr_load_o,
  output logic [CNT_W-1:0] tmr_val_o,
  output logic             tmr_run_o,
  output logic             conv_end_o,
  output logic             release_o,
  output logic             powered_o,
  output logic             converting_o
);
  localparam logic [CNT_W-1:0] PWRUP_LOAD = CNT_W'(PWRUP_CYC - 1);
  localparam logic [CNT_W-1:0] CONV_LOAD  = CNT_W'(CONV_CYC - 1);

  seq_state_t st_q, st_d;
  logic       fall_seen_q, fall_seen_d;
  logic       stay_q, stay_d;

  always_comb begin
    st_d        = st_q;
    fall_seen_d = fall_seen_q;
    stay_d      = stay_q;
    tmr_load_o  = 1'b0;
    tmr_val_o   = CONV_LOAD;
    conv_end_o  = 1'b0;
    release_o   = 1'b0;
    unique case (st_q)
      SQ_OFF: begin
        fall_seen_d = 1'b0;
        if (cs_rise_i) begin
          st_d       = SQ_WAKE;
          tmr_load_o = 1'b1;
          tmr_val_o  = PWRUP_LOAD;
        end
      end
      SQ_WAKE: begin
        if (cs_fall_i) fall_seen_d = 1'b1;
        if (tmr_done_i) begin
          fall_seen_d = 1'b0;
          if (fall_seen_q | cs_fall_i) begin
            st_d       = SQ_CONV;
            tmr_load_o = 1'b1;
          end else begin
            st_d = SQ_READY;
          end
        end
      end
      SQ_READY: begin
        if (cs_fall_i) begin
          st_d       = SQ_CONV;
          tmr_load_o = 1'b1;
        end
      end
      SQ_CONV: begin
        if (tmr_done_i) begin
          conv_end_o = 1'b1;
          stay_d     = cs_lvl_i;
          if (busy_i)        st_d = SQ_PEND;
          else if (cs_lvl_i) st_d = SQ_READY;
          else               st_d = SQ_OFF;
        end
      end
      SQ_PEND: begin
        if (!busy_i) begin
          release_o = 1'b1;
          st_d      = stay_q ? SQ_READY : SQ_OFF;
        end
      end
      default: st_d = SQ_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= SQ_OFF;
      fall_seen_q <= 1'b0;
      stay_q      <= 1'b0;
    end else begin
      st_q        <= st_d;
      fall_seen_q <= fall_seen_d;
      stay_q      <= stay_d;
    end
  end

  assign tmr_run_o    = (st_q == SQ_WAKE) | (st_q == SQ_CONV);
  assign powered_o    = (st_q != SQ_OFF);
  assign converting_o = (st_q == SQ_CONV) | (st_q == SQ_PEND);
endmodule

// File: rtl/adc_seq_outreg.sv
module adc_seq_outreg #(
  parameter int DATA_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              conv_end_i,
  input  logic              busy_i,
  input  logic              release_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              latch_o,
  output logic [DATA_W-1:0] result_o
);
  logic [DATA_W-1:0] res_q, park_q, res_d;
  logic              res_en, park_en, latch_d;

  always_comb begin
    park_en = conv_end_i & busy_i;
    res_en  = (conv_end_i & ~busy_i) | release_i;
    res_d   = release_i ? park_q : data_i;
    latch_d = res_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q   <= '0;
      park_q  <= '0;
      latch_o <= 1'b0;
    end else begin
      latch_o <= latch_d;
      if (res_en)  res_q  <= res_d;
      if (park_en) park_q <= data_i;
    end
  end

  assign result_o = res_q;
endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq #(
  parameter int DATA_W    = 10,
  parameter int PWRUP_CYC = 75,
  parameter int CONV_CYC  = 115
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnv_start_i,
  input  logic              read_busy_i,
  input  logic [DATA_W-1:0] conv_data_i,
  output logic              powered_o,
  output logic              converting_o,
  output logic              latch_o,
  output logic [DATA_W-1:0] result_o
);
  localparam int MAX_CYC = (PWRUP_CYC > CONV_CYC) ? PWRUP_CYC : CONV_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  logic             rst_meta_q, rst_sync_n;
  logic             cs_lvl, cs_rise, cs_fall;
  logic             tmr_load, tmr_run, tmr_done;
  logic [CNT_W-1:0] tmr_val;
  logic             conv_end, rel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  adc_seq_sync u_sync (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .async_i(cnv_start_i),
    .lvl_o  (cs_lvl),
    .rise_o (cs_rise),
    .fall_o (cs_fall)
  );

  adc_seq_timer #(.CNT_W(CNT_W)) u_timer (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .load_i    (tmr_load),
    .load_val_i(tmr_val),
    .run_i     (tmr_run),
    .done_o    (tmr_done)
  );

  adc_seq_ctrl #(
    .PWRUP_CYC(PWRUP_CYC),
    .CONV_CYC (CONV_CYC),
    .CNT_W    (CNT_W)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .cs_lvl_i    (cs_lvl),
    .cs_rise_i   (cs_rise),
    .cs_fall_i   (cs_fall),
    .busy_i      (read_busy_i),
    .tmr_done_i  (tmr_done),
    .tmr_load_o  (tmr_load),
    .tmr_val_o   (tmr_val),
    .tmr_run_o   (tmr_run),
    .conv_end_o  (conv_end),
    .release_o   (rel),
    .powered_o   (powered_o),
    .converting_o(converting_o)
  );

  adc_seq_outreg #(.DATA_W(DATA_W)) u_outreg (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .conv_end_i(conv_end),
    .busy_i    (read_busy_i),
    .release_i (rel),
    .data_i    (conv_data_i),
    .latch_o   (latch_o),
    .result_o  (result_o)
  );
endmodule

// File: rtl/adc_conv_seq_chk.sv
module adc_conv_seq_chk #(
  parameter int DATA_W    = 10,
  parameter int PWRUP_CYC = 75,
  parameter int CONV_CYC  = 115
) (
  input logic              clk,
  input logic              rst_n,
  input logic              read_busy_i,
  input logic              powered_o,
  input logic              converting_o,
  input logic              latch_o,
  input logic [DATA_W-1:0] result_o
);
  logic [15:0] conv_cnt, pwr_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      conv_cnt <= '0;
      pwr_cnt  <= '0;
    end else begin
      if (!converting_o)         conv_cnt <= '0;
      else if (conv_cnt != '1)   conv_cnt <= conv_cnt + 1'b1;
      if (!powered_o)            pwr_cnt  <= '0;
      else if (pwr_cnt != '1)    pwr_cnt  <= pwr_cnt + 1'b1;
    end
  end

  assert_conv_min_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(converting_o) |-> (conv_cnt >= 16'(CONV_CYC)));
  assert_latch_at_end_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(converting_o) |-> latch_o);
  assert_strobe_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    latch_o |=> !latch_o);
  assert_pwrdown_on_latch_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(powered_o) |-> latch_o);
  assert_pwrup_elapsed_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(converting_o) |-> (pwr_cnt >= 16'(PWRUP_CYC)));
  assert_conv_powered_R6: assert property (@(posedge clk) disable iff (!rst_n)
    converting_o |-> powered_o);
  assert_defer_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    latch_o |-> !$past(read_busy_i));
  assert_result_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !latch_o |-> $stable(result_o));
endmodule

bind adc_conv_seq adc_conv_seq_chk #(
  .DATA_W(DATA_W), .PWRUP_CYC(PWRUP_CYC), .CONV_CYC(CONV_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .read_busy_i(read_busy_i), .powered_o(powered_o),
  .converting_o(converting_o), .latch_o(latch_o), .result_o(result_o)
);

// File: tb/adc_conv_seq_bench.sv
module adc_conv_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 10;
  localparam int PW = 6;
  localparam int CV = 10;
  localparam int NVEC = 5;
  // [11] convert-start level at end, [10] read busy at end, [9:0] data
  localparam logic [11:0] VEC [NVEC] = '{
    {1'b1, 1'b0, 10'h2A5},
    {1'b1, 1'b1, 10'h15A},
    {1'b0, 1'b0, 10'h3FF},
    {1'b0, 1'b1, 10'h001},
    {1'b1, 1'b0, 10'h200}
  };

  logic clk = 1'b0;
  logic rst_n, cs, busy;
  logic [DW-1:0] din;
  logic powered, converting, latch;
  logic [DW-1:0] result;
  int checks = 0, errors = 0;
  bit finished = 1'b0;
  logic [DW-1:0] prev_res;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_conv_seq #(.DATA_W(DW), .PWRUP_CYC(PW), .CONV_CYC(CV)) u_adc_conv_seq (
    .clk(clk), .rst_n(rst_n), .cnv_start_i(cs), .read_busy_i(busy),
    .conv_data_i(din), .powered_o(powered), .converting_o(converting),
    .latch_o(latch), .result_o(result)
  );

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wake_long();
    cs = 1'b1;
    repeat (PW + 6) step();
    chk(powered == 1'b1, "R5 powered after long pulse", int'(powered), 1);
    chk(converting == 1'b0, "R5 idle after long pulse", int'(converting), 0);
  endtask

  task automatic start_conv();
    cs = 1'b0;
    for (int i = 1; i <= 3; i++) begin
      step();
      if (i == 2) chk(converting == 1'b0, "R5 fall latency early", int'(converting), 0);
      if (i == 3) chk(converting == 1'b1, "R5 fall latency", int'(converting), 1);
    end
  endtask

  initial begin
    rst_n = 1'b0; cs = 1'b0; busy = 1'b0; din = '0;
    prev_res = '0;
    repeat (3) step();
    rst_n = 1'b1;
    repeat (3) step();
    chk(powered == 1'b0, "R1 powered", int'(powered), 0);
    chk(converting == 1'b0, "R1 converting", int'(converting), 0);
    chk(latch == 1'b0, "R1 latch", int'(latch), 0);
    chk(result == '0, "R1 result", int'(result), 0);

    for (int v = 0; v < NVEC; v++) begin
      logic mode, bz;
      logic [DW-1:0] d;
      int n;
      mode = VEC[v][11]; bz = VEC[v][10]; d = VEC[v][9:0];
      if (v == 1) chk(powered == 1'b1, "R3 stays powered", int'(powered), 1);
      if (!powered) wake_long();
      din = d; busy = bz;
      start_conv();
      step(); step();
      cs = mode;
      chk(result == prev_res, "R8 previous result during conversion", int'(result), int'(prev_res));
      if (bz) begin
        repeat (CV + 2) step();
        chk(converting == 1'b1, "R7 converting held", int'(converting), 1);
        chk(latch == 1'b0, "R7 no latch while busy", int'(latch), 0);
        chk(result == prev_res, "R7 result held", int'(result), int'(prev_res));
        din = ~d; busy = 1'b0;
        step();
        chk(latch == 1'b1, "R7 latch after read", int'(latch), 1);
        chk(result == d, "R7 captured data", int'(result), int'(d));
        chk(converting == 1'b0, "R7 converting drops", int'(converting), 0);
      end else begin
        n = 3;
        for (int k = 0; k < 100; k++) begin
          step();
          if (!converting) break;
          n++;
        end
        chk(n == CV, "R2 conversion length", n, CV);
        chk(latch == 1'b1, "R2 latch at end", int'(latch), 1);
        chk(result == d, "R2 result", int'(result), int'(d));
      end
      if (mode) chk(powered == 1'b1, "R3 powered after high end", int'(powered), 1);
      else      chk(powered == 1'b0, "R4 powered down after low end", int'(powered), 0);
      prev_res = d;
      step();
      chk(latch == 1'b0, "R2 strobe one cycle", int'(latch), 0);
    end

    // R9: toggling convert-start inside a conversion, ending low
    begin
      int n, nl;
      din = 10'h0F0;
      start_conv();
      step(); cs = 1'b1;
      step(); cs = 1'b0;
      step(); cs = 1'b1;
      step(); cs = 1'b0;
      n = 5; nl = 0;
      for (int k = 0; k < 100; k++) begin
        step();
        if (!converting) break;
        n++;
      end
      chk(n == CV, "R9 length unchanged by edges", n, CV);
      chk(result == 10'h0F0, "R9 result", int'(result), 'h0F0);
      for (int k = 0; k < 6; k++) begin
        if (latch) nl++;
        step();
      end
      chk(nl == 1, "R9 single strobe", nl, 1);
      chk(powered == 1'b0, "R4 powered down", int'(powered), 0);
      prev_res = 10'h0F0;
    end

    // R6: short wake pulse, conversion waits for the power-up interval
    din = 10'h333;
    cs = 1'b1;
    for (int i = 1; i <= PW + 3; i++) begin
      step();
      if (i == 1) cs = 1'b0;
      if (i == 3) chk(powered == 1'b1, "R6 power-up starts", int'(powered), 1);
      if (i == PW + 2) chk(converting == 1'b0, "R6 not before power-up", int'(converting), 0);
      if (i == PW + 3) chk(converting == 1'b1, "R6 starts after power-up", int'(converting), 1);
    end
    chk(result == prev_res, "R8 result held in conversion", int'(result), int'(prev_res));
    repeat (CV + 2) step();
    chk(result == 10'h333, "R6 result", int'(result), 'h333);
    chk(powered == 1'b0, "R4 powered down after short pulse", int'(powered), 0);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule